// File: doc/BRIEF.md
# Multi-Issue Fetch and Decode Stage

This block is the front end of a small in-order pipeline. Each cycle it presents a program counter to an instruction memory and gets back a window of consecutive 32-bit words. It decodes as many of them as the four-entry pre-issue queue can take and appends them to the queue in program order. Decoding splits each word into an operation class, an opcode, a destination, two sources and a sign-extended offset. The class tells later stages which pipeline the instruction goes to: logical, arithmetic or memory.

The issue stage sees the queue head through a valid vector and a packed array of decoded entries. It removes entries from the head by driving a removal count. Entries it removes become free slots for the next cycle's fetch, not for the fetch in the same cycle. The program counter moves forward by exactly the number of words taken, so nothing is skipped or fetched twice when the queue backs up.

Top module: `fetch_decode_stage`

## Requirements
- R1: While reset is active, and for the two clock edges that the internal reset synchroniser takes after `rst_n` rises, `q_vld` is 0 and `imem_addr` equals the reset address (default 0).
- R2: The number of words taken in a cycle equals min(FETCH_W, DEPTH minus the occupancy at the start of that cycle). Removals requested in the same cycle do not raise that count.
- R3: Occupancy never exceeds DEPTH. `q_vld` is a thermometer code in which bit i is 1 exactly when more than i entries are held.
- R4: Words presented at `imem_addr` in a cycle appear decoded in the queue after the next rising clock edge.
- R5: The queue keeps program order. Entry 0 is the oldest, and a removal count of n drops entries 0..n-1 and moves the rest towards the head.
- R6: `imem_addr` advances by the number of words taken, and it stays unchanged while the queue is full at the start of a cycle.
- R7: The class field holds one of four codes. Opcode 3 (AND) and opcode 4 (OR) give 0 (logical). Opcode 1 (ADD) and opcode 2 (SUB) give 1 (arithmetic). Opcode 5 (LD) and opcode 6 (ST) give 2 (memory). Every other opcode gives 3 (illegal).
- R8: In the instruction word, bits [31:28] are the opcode, [27:23] the destination, [22:18] the first source or base, [17:13] the second source or store data, and [12:0] the offset. In each 37-bit entry, bits [36:35] are the class, [34:31] the opcode, [30:26] the destination, [25:21] source 1, [20:16] source 2 and [15:0] the offset, which is bit 12 of the word sign-extended.
- R9: A removal count larger than the occupancy removes all held entries and nothing more.
- R10: Word i of `imem_rdata` (bits [32i+31:32i]) is taken as the instruction at address `imem_addr`+i, and the words are appended in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| imem_addr | output | PC_W | Word address of the first word in the fetch window |
| imem_rdata | input | 32*FETCH_W | Instruction words at imem_addr onward, word 0 in the low bits |
| deq_cnt | input | $clog2(DEPTH+1) | Number of head entries the issue stage removes this cycle |
| q_vld | output | DEPTH | Occupancy thermometer, bit 0 for the head |
| q_ent | output | 37*DEPTH | Decoded entries, entry 0 (oldest) in the low bits |

## Verification
On every cycle the assertions check that occupancy stays within the queue size, that the fetch count never overfills the slots free at the start of the cycle, and that the program counter holds while the queue is full. They also check that the head entry is stable when nothing is removed, and that an oversized removal empties the queue down to just the new arrivals. Only the bench's scenarios can show that the right words reach the right slots in order, that each opcode gets its class, and that every field, including the sign-extended offset, is extracted from its bit positions. The scenarios also show that a removal in a cycle frees slots only for the following fetch.

// File: rtl/fd_pkg.sv
package fd_pkg;

  localparam int INSTR_W = 32;
  localparam int OP_W    = 4;
  localparam int REG_W   = 5;
  localparam int IMM_W   = 13;
  localparam int OFF_W   = 16;

  localparam logic [OP_W-1:0] OPC_ADD = 4'd1;
  localparam logic [OP_W-1:0] OPC_SUB = 4'd2;
  localparam logic [OP_W-1:0] OPC_AND = 4'd3;
  localparam logic [OP_W-1:0] OPC_OR  = 4'd4;
  localparam logic [OP_W-1:0] OPC_LD  = 4'd5;
  localparam logic [OP_W-1:0] OPC_ST  = 4'd6;

  typedef enum logic [1:0] {
    CLS_LOGIC = 2'd0,
    CLS_ARITH = 2'd1,
    CLS_MEM   = 2'd2,
    CLS_ILL   = 2'd3
  } op_cls_e;

  typedef struct packed {
    op_cls_e             cls;
    logic [OP_W-1:0]     op;
    logic [REG_W-1:0]    rd;
    logic [REG_W-1:0]    rs1;
    logic [REG_W-1:0]    rs2;
    logic [OFF_W-1:0]    off;
  } fd_entry_t;

  localparam int ENT_W = $bits(fd_entry_t);

endpackage

// File: rtl/fd_decoder.sv
module fd_decoder
  import fd_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output fd_entry_t          ent
);

  always_comb begin
    ent.op  = instr[31:28];
    ent.rd  = instr[27:23];
    ent.rs1 = instr[22:18];
    ent.rs2 = instr[17:13];
    ent.off = {{(OFF_W-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};
    unique case (instr[31:28])
      OPC_AND, OPC_OR: ent.cls = CLS_LOGIC;
      OPC_ADD, OPC_SUB: ent.cls = CLS_ARITH;
      OPC_LD, OPC_ST:  ent.cls = CLS_MEM;
      default:         ent.cls = CLS_ILL;
    endcase
  end

endmodule

// File: rtl/fd_fetch_ctrl.sv
module fd_fetch_ctrl #(
  parameter int              DEPTH    = 4,
  parameter int              FETCH_W  = 4,
  parameter int              PC_W     = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int             CNT_W    = $clog2(DEPTH+1),
  localparam int             FN_W     = $clog2(FETCH_W+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] occ,
  output logic [PC_W-1:0]  pc,
  output logic [FN_W-1:0]  fetch_n
);

  logic [CNT_W-1:0] free_slots;
  logic [PC_W-1:0]  pc_nxt;
  logic             pc_en;

  always_comb begin
    free_slots = CNT_W'(DEPTH) - occ;
    if (int'(free_slots) > FETCH_W) fetch_n = FN_W'(FETCH_W);
    else                            fetch_n = FN_W'(free_slots);
    pc_en  = (fetch_n != '0);
    pc_nxt = pc + PC_W'(fetch_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc <= RESET_PC;
    else if (pc_en) pc <= pc_nxt;
  end

  AST_PC_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(occ) == DEPTH) |=> $stable(pc)); // R6

endmodule

// File: rtl/fd_queue.sv
module fd_queue
  import fd_pkg::*;
#(
  parameter int  DEPTH   = 4,
  parameter int  FETCH_W = 4,
  localparam int CNT_W   = $clog2(DEPTH+1),
  localparam int FN_W    = $clog2(FETCH_W+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FN_W-1:0]  fetch_n,
  input  fd_entry_t        fetch_ent [FETCH_W],
  input  logic [CNT_W-1:0] deq_cnt,
  output logic [CNT_W-1:0] count,
  output fd_entry_t        ent_q [DEPTH]
);

  fd_entry_t        ent_nxt [DEPTH];
  logic [CNT_W-1:0] count_nxt;
  logic             ent_en;

  always_comb begin
    int cnt_i, deq_i, keep_i, fn_i;
    cnt_i  = int'(count);
    fn_i   = int'(fetch_n);
    deq_i  = (int'(deq_cnt) > cnt_i) ? cnt_i : int'(deq_cnt);
    keep_i = cnt_i - deq_i;
    for (int i = 0; i < DEPTH; i++) begin
      ent_nxt[i] = ent_q[i];
      if (i < keep_i)
        ent_nxt[i] = ent_q[i + deq_i];
      else if ((i - keep_i) < fn_i)
        ent_nxt[i] = fetch_ent[i - keep_i];
    end
    count_nxt = CNT_W'(keep_i + fn_i);
    ent_en    = (deq_i != 0) || (fn_i != 0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end

  always_ff @(posedge clk) begin
    if (ent_en) ent_q <= ent_nxt;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH); // R3

  AST_FETCH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fetch_n) + int'(count)) <= DEPTH); // R2

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0 && deq_cnt == '0) |=> (ent_q[0] == $past(ent_q[0]))); // R5

  AST_CLAMP_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_cnt > count) |=> (int'(count) == int'($past(fetch_n)))); // R9

endmodule

// File: rtl/fetch_decode_stage.sv
module fetch_decode_stage
  import fd_pkg::*;
#(
  parameter int              DEPTH    = 4,
  parameter int              FETCH_W  = 4,
  parameter int              PC_W     = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic [PC_W-1:0]              imem_addr,
  input  logic [FETCH_W*INSTR_W-1:0]   imem_rdata,
  input  logic [$clog2(DEPTH+1)-1:0]   deq_cnt,
  output logic [DEPTH-1:0]             q_vld,
  output logic [DEPTH*ENT_W-1:0]       q_ent
);

  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int FN_W  = $clog2(FETCH_W+1);

  logic             rst_meta_n, rst_sync_n;
  logic [CNT_W-1:0] occ;
  logic [FN_W-1:0]  fetch_n;
  logic [PC_W-1:0]  pc;
  fd_entry_t        dec_ent [FETCH_W];
  fd_entry_t        q_arr   [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  for (genvar g = 0; g < FETCH_W; g++) begin : g_dec
    fd_decoder u_dec (
      .instr (imem_rdata[g*INSTR_W +: INSTR_W]),
      .ent   (dec_ent[g])
    );
  end

  fd_fetch_ctrl #(
    .DEPTH    (DEPTH),
    .FETCH_W  (FETCH_W),
    .PC_W     (PC_W),
    .RESET_PC (RESET_PC)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .occ     (occ),
    .pc      (pc),
    .fetch_n (fetch_n)
  );

  fd_queue #(
    .DEPTH   (DEPTH),
    .FETCH_W (FETCH_W)
  ) u_queue (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fetch_n   (fetch_n),
    .fetch_ent (dec_ent),
    .deq_cnt   (deq_cnt),
    .count     (occ),
    .ent_q     (q_arr)
  );

  assign imem_addr = pc;

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign q_vld[g]                 = (occ > CNT_W'(g));
    assign q_ent[g*ENT_W +: ENT_W]  = q_arr[g];
  end

  AST_PC_TRACKS_FILL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fetch_n != '0) |=> (imem_addr != $past(imem_addr))); // R6

endmodule

// File: tb/test_fetch_decode_stage.sv
`timescale 1ns/100ps
module test_fetch_decode_stage;

  localparam int DEPTH = 4;
  localparam int FW    = 4;
  localparam int PC_W  = 16;
  localparam int EW    = 37;

  logic                 clk;
  logic                 rst_n;
  logic [PC_W-1:0]      imem_addr;
  logic [FW*32-1:0]     imem_rdata;
  logic [2:0]           deq_cnt;
  logic [DEPTH-1:0]     q_vld;
  logic [DEPTH*EW-1:0]  q_ent;

  int checks = 0;
  int errors = 0;
  int exp_cnt, exp_pc;
  int exp_q [DEPTH];

  fetch_decode_stage i_fetch_decode_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .deq_cnt    (deq_cnt),
    .q_vld      (q_vld),
    .q_ent      (q_ent)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  function automatic logic [31:0] mk_instr(input int a);
    logic [3:0]  op;
    logic [4:0]  rd, s1, s2;
    logic [12:0] im;
    op = 4'(a % 16);
    rd = 5'((a * 7 + 3) % 32);
    s1 = 5'((a * 11 + 5) % 32);
    s2 = 5'((a * 13 + 1) % 32);
    im = 13'((a * 1237 + 91) % 8192);
    return {op, rd, s1, s2, im};
  endfunction

  function automatic int exp_class(input int op);
    case (op)
      3, 4:    return 0;
      1, 2:    return 1;
      5, 6:    return 2;
      default: return 3;
    endcase
  endfunction

  always_comb begin
    for (int i = 0; i < FW; i++)
      imem_rdata[i*32 +: 32] = mk_instr(int'(imem_addr) + i);
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic check_state();
    logic [31:0] w;
    logic [EW-1:0] e;
    int thermo;
    thermo = (1 << exp_cnt) - 1;
    chk(int'(q_vld) == thermo, "R3 occupancy thermometer", int'(q_vld), thermo);
    chk(int'(imem_addr) == exp_pc, "R6 fetch address", int'(imem_addr), exp_pc);
    for (int i = 0; i < exp_cnt; i++) begin
      w = mk_instr(exp_q[i]);
      e = q_ent[i*EW +: EW];
      chk(int'(e[34:31]) == int'(w[31:28]), "R5 entry order (opcode of slot)",
          int'(e[34:31]), int'(w[31:28]));
      chk(int'(e[36:35]) == exp_class(int'(w[31:28])), "R7 class",
          int'(e[36:35]), exp_class(int'(w[31:28])));
      chk(e[30:16] == {w[27:23], w[22:18], w[17:13]}, "R8 register fields",
          int'(e[30:16]), int'({w[27:23], w[22:18], w[17:13]}));
      chk(e[15:0] == {{3{w[12]}}, w[12:0]}, "R8 offset sign extension",
          int'(e[15:0]), int'({{3{w[12]}}, w[12:0]}));
    end
  endtask

  // Drives removals for one clock edge, advances the model, checks after the edge.
  task automatic cyc(input int d);
    int f, dd;
    deq_cnt = 3'(d);
    f  = (DEPTH - exp_cnt > FW) ? FW : DEPTH - exp_cnt;
    dd = (d > exp_cnt) ? exp_cnt : d;
    for (int i = 0; i < DEPTH; i++)
      if (i + dd < exp_cnt) exp_q[i] = exp_q[i + dd];
    for (int k = 0; k < f; k++)
      exp_q[exp_cnt - dd + k] = exp_pc + k;
    exp_cnt = exp_cnt - dd + f;
    exp_pc  = (exp_pc + f) % (1 << PC_W);
    @(negedge clk);
    deq_cnt = 3'd0;
    check_state();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    deq_cnt = 3'd0;
    exp_cnt = 0;
    exp_pc  = 0;
    repeat (3) @(negedge clk);
    chk(q_vld == '0, "R1 queue empty in reset", int'(q_vld), 0);
    chk(imem_addr == '0, "R1 address in reset", int'(imem_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(q_vld == '0, "R1 queue empty during reset release", int'(q_vld), 0);
    chk(imem_addr == '0, "R1 address during reset release", int'(imem_addr), 0);
  endtask

  task automatic t_fill_and_hold();
    cyc(0);
    chk(q_vld == 4'hF, "R4 four words one edge after presentation", int'(q_vld), 15);
    chk(imem_addr == 16'd4, "R2 four taken from empty queue", int'(imem_addr), 4);
    for (int n = 0; n < 3; n++) begin
      cyc(0);
      chk(imem_addr == 16'd4, "R6 address held while full", int'(imem_addr), 4);
    end
  endtask

  task automatic t_same_cycle_credit();
    cyc(1);
    chk(q_vld == 4'h7, "R2 removal not credited to same-cycle fetch", int'(q_vld), 7);
    chk(imem_addr == 16'd4, "R2 nothing taken while full at cycle start", int'(imem_addr), 4);
    cyc(0);
    chk(q_vld == 4'hF, "R2 freed slot refilled next cycle", int'(q_vld), 15);
    chk(imem_addr == 16'd5, "R10 one word taken", int'(imem_addr), 5);
  endtask

  task automatic t_drain_clamp();
    cyc(4);
    chk(q_vld == 4'h0, "R5 full removal empties queue", int'(q_vld), 0);
    cyc(0);
    chk(q_vld == 4'hF, "R10 refill window from address 5", int'(q_vld), 15);
    cyc(2);
    cyc(7);
    chk(q_vld == 4'h2 + 4'h1, "R9 oversized removal keeps only new words",
        int'(q_vld), 3);
  endtask

  task automatic t_mixed();
    for (int k = 0; k < 60; k++) cyc((k * 7 + 3) % 6);
    for (int k = 0; k < 6; k++) cyc(0);
    chk(q_vld == 4'hF, "R3 full after idle issue", int'(q_vld), 15);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_fill_and_hold();
    t_same_cycle_credit();
    t_drain_clamp();
    t_mixed();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule